// File: doc/BRIEF.md
# Track Word Formatter

This block turns the five raw track bits of an absolute optical encoder into the word that is presented on the parallel output. Track bit 0 is the finest track and bit 4 the coarsest. Three active-low controls shape the word.

The first control reverses the counting direction by flipping only the most significant bit. The second flips every bit, for discs printed with inverted Gray code. The third selects a Gray-to-binary conversion, which is applied after both flips. When both flip controls are low, the two flips cancel on the MSB: every bit except the top one comes out inverted. With all three controls held high the track word passes through untouched, so high is the safe idle setting.

The datapath is combinational. A parameter selects whether a result register follows it, which gives one clock of latency, or whether the result is passed straight out. The same formatter is intended to sit ahead of a serial shifter as well as driving pins.

Top module: `track_formatter`

## Requirements
- R1: With `rev_dir_n` low and `flip_all_n` high, only output bit 4 (MSB) differs from the track word before conversion.
- R2: With `flip_all_n` low and `rev_dir_n` high, all five bits are inverted before conversion.
- R3: With both `rev_dir_n` and `flip_all_n` low, bit 4 keeps its track value and bits 3..0 are inverted before conversion.
- R4: With `keep_gray` low, the flipped word is converted from Gray to binary: output bit i is the XOR of flipped bits i through 4, so bit 4 is unchanged and bit 0 is the parity of the whole word.
- R5: With `keep_gray` high, the flipped word is output as it is, still in Gray code.
- R6: With all three controls high, output bit i equals `track_i` bit i for every i (bit 0 = LSB, bit 4 = MSB).
- R7: With `REG_OUT` = 1, `word_o` shows the result of the inputs sampled at the previous rising clock edge.
- R8: A high `rst` at a rising clock edge clears `word_o` to all zeros at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| track_i | input | 5 | Raw track bits, bit 4 = coarsest track |
| rev_dir_n | input | 1 | Low: flip the MSB to reverse count direction |
| flip_all_n | input | 1 | Low: flip every track bit |
| keep_gray | input | 1 | High: output Gray code; low: output binary |
| word_o | output | 5 | Formatted output word |

## Verification
Every one of the 32 track codes is applied under each of the 8 control settings in an unbroken stream, with new inputs on every cycle. This separates an MSB-only flip from a full flip and shows the cancellation on the MSB when both are active. Running the full code space through the binary setting catches a wrong conversion order or direction, since converting before flipping gives different words for most codes. Changing inputs each cycle shows the one-cycle latency. A reset asserted while the input is all ones shows that reset clears the output rather than loading the input.

// File: rtl/trackfmt_pkg.sv
package trackfmt_pkg;

    localparam int TRACKS = 5;

    // Control set, decoded to active-high internal sense
    typedef struct packed {
        logic rev_msb;    // flip the top bit only
        logic inv_all;    // flip every bit
        logic to_binary;  // convert Gray to binary
    } fmt_ctrl_t;

    function automatic fmt_ctrl_t decode_ctrl(input logic rev_n,
                                              input logic flip_n,
                                              input logic gray_keep);
        fmt_ctrl_t c;
        c.rev_msb   = ~rev_n;
        c.inv_all   = ~flip_n;
        c.to_binary = ~gray_keep;
        return c;
    endfunction

endpackage

// File: rtl/trackfmt_invert.sv
module trackfmt_invert
    import trackfmt_pkg::*;
#(
    parameter int W = TRACKS
) (
    input  logic [W-1:0] raw_i,
    input  fmt_ctrl_t    ctrl_i,
    output logic [W-1:0] flip_o
);
    localparam int TOP = W - 1;

    logic [W-1:0] mask;

    always_comb begin
        mask      = {W{ctrl_i.inv_all}};
        mask[TOP] = ctrl_i.inv_all ^ ctrl_i.rev_msb;
        flip_o    = raw_i ^ mask;
    end
endmodule

// File: rtl/trackfmt_gray2bin.sv
module trackfmt_gray2bin #(
    parameter int W = 5
) (
    input  logic [W-1:0] code_i,
    input  logic         en_i,
    output logic [W-1:0] code_o
);
    logic [W-1:0] bin;

    assign bin[W-1] = code_i[W-1];

    generate
        for (genvar i = W - 2; i >= 0; i--) begin : g_chain
            assign bin[i] = code_i[i] ^ bin[i+1];
        end
    endgenerate

    assign code_o = en_i ? bin : code_i;
endmodule

// File: rtl/trackfmt_outreg.sv
module trackfmt_outreg #(
    parameter int W       = 5,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    generate
        if (REG_OUT) begin : g_reg
            logic [W-1:0] q_r;
            always_ff @(posedge clk) begin
                if (rst) q_r <= '0;
                else     q_r <= d_i;
            end
            assign q_o = q_r;
        end else begin : g_pass
            logic unused_clk_rst;
            assign unused_clk_rst = clk ^ rst;
            assign q_o = d_i;
        end
    endgenerate
endmodule

// File: rtl/track_formatter.sv
module track_formatter
    import trackfmt_pkg::*;
#(
    parameter int W       = TRACKS,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] track_i,
    input  logic         rev_dir_n,
    input  logic         flip_all_n,
    input  logic         keep_gray,
    output logic [W-1:0] word_o
);
    localparam int TOP = W - 1;

    fmt_ctrl_t    ctrl;
    logic [W-1:0] flipped;
    logic [W-1:0] converted;

    assign ctrl = decode_ctrl(rev_dir_n, flip_all_n, keep_gray);

    trackfmt_invert #(.W(W)) u_invert (
        .raw_i  (track_i),
        .ctrl_i (ctrl),
        .flip_o (flipped)
    );

    trackfmt_gray2bin #(.W(W)) u_conv (
        .code_i (flipped),
        .en_i   (ctrl.to_binary),
        .code_o (converted)
    );

    trackfmt_outreg #(.W(W), .REG_OUT(REG_OUT)) u_out (
        .clk (clk),
        .rst (rst),
        .d_i (converted),
        .q_o (word_o)
    );

    // Flip stage checks
    assert_msb_only_R1: assert property (@(posedge clk) disable iff (rst)
        (!rev_dir_n && flip_all_n) |-> (flipped[TOP-1:0] == track_i[TOP-1:0]
                                        && flipped[TOP] != track_i[TOP]));

    assert_low_bits_flip_R2: assert property (@(posedge clk) disable iff (rst)
        !flip_all_n |-> (flipped[TOP-1:0] == ~track_i[TOP-1:0]));

    assert_msb_cancel_R3: assert property (@(posedge clk) disable iff (rst)
        (!rev_dir_n && !flip_all_n) |-> (flipped[TOP] == track_i[TOP]));

    // Conversion stage checks
    assert_parity_lsb_R4: assert property (@(posedge clk) disable iff (rst)
        !keep_gray |-> (converted[0] == ^flipped && converted[TOP] == flipped[TOP]));

    assert_gray_pass_R5: assert property (@(posedge clk) disable iff (rst)
        keep_gray |-> (converted == flipped));

    generate
        if (REG_OUT) begin : g_reg_checks
            assert_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> (word_o == $past(converted)));

            assert_reset_clear_R8: assert property (@(posedge clk)
                rst |=> (word_o == '0));
        end
    endgenerate
endmodule

// File: tb/test_track_formatter.sv
module test_track_formatter;

    localparam int W = 5;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] track_i = '0;
    logic         rev_dir_n = 1'b1;
    logic         flip_all_n = 1'b1;
    logic         keep_gray = 1'b1;
    logic [W-1:0] word_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    track_formatter #(.W(W), .REG_OUT(1'b1)) i_track_formatter (
        .clk        (clk),
        .rst        (rst),
        .track_i    (track_i),
        .rev_dir_n  (rev_dir_n),
        .flip_all_n (flip_all_n),
        .keep_gray  (keep_gray),
        .word_o     (word_o)
    );

    // Behavioural reference: integer arithmetic, shift-based decode
    function automatic int ref_word(int t, bit rev_n, bit flip_n, bit gk);
        int v = t;
        if (!flip_n) v = v ^ 31;
        if (!rev_n)  v = v ^ 16;
        if (!gk) begin
            int b = v;
            for (int s = 1; s < W; s++) b = b ^ (v >> s);
            v = b;
        end
        return v & 31;
    endfunction

    // Requirement tags: R1 MSB only, R2 all, R3 both, R6 none; R4 binary, R5 Gray
    function automatic string ref_tag(bit rev_n, bit flip_n, bit gk);
        string a, b;
        if (!rev_n && !flip_n)  a = "R3";
        else if (!rev_n)        a = "R1";
        else if (!flip_n)       a = "R2";
        else                    a = "R6";
        b = gk ? "R5" : "R4";
        return {a, "/", b, "/R7"};
    endfunction

    task automatic check(string tag, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: word_o=%0d expected %0d (t=%0t)", tag, got, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, 5000);
            finish_run();
        end
    end

    initial begin
        int    prev_exp;
        string prev_tag;
        bit    have_prev;
        have_prev = 0;
        prev_exp  = 0;
        prev_tag  = "";

        // R8: reset state
        repeat (3) @(negedge clk);
        check("R8 reset state", int'(word_o), 0);
        rst = 1'b0;

        // Full sweep: 8 control settings x 32 codes, new input every cycle
        for (int c = 0; c < 8; c++) begin
            for (int t = 0; t < 32; t++) begin
                @(negedge clk);
                if (have_prev) check(prev_tag, int'(word_o), prev_exp);
                rev_dir_n  = c[0];
                flip_all_n = c[1];
                keep_gray  = c[2];
                track_i    = t[W-1:0];
                prev_exp   = ref_word(t, c[0], c[1], c[2]);
                prev_tag   = ref_tag(c[0], c[1], c[2]);
                have_prev  = 1;
            end
        end
        @(negedge clk);
        check(prev_tag, int'(word_o), prev_exp);

        // R6: bit order with single-bit patterns, pass-through settings
        rev_dir_n = 1'b1; flip_all_n = 1'b1; keep_gray = 1'b1;
        for (int i = 0; i < W; i++) begin
            track_i = W'(1 << i);
            @(negedge clk);
            check("R6 bit position", int'(word_o), 1 << i);
        end

        // R8: reset while input is all ones must clear, not load
        track_i = '1;
        rst = 1'b1;
        @(negedge clk);
        check("R8 mid-run reset", int'(word_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R7 after reset release", int'(word_o), 31);

        done = 1;
        finish_run();
    end

endmodule